// File: doc/BRIEF.md
# Phase-Encoded Line Decoder

This block takes one raw phase-encoded serial line and samples it eight times per nominal bit cell. A small counter measures how many samples have passed since the last data transition. The timing of each line transition decides what that transition is: a data bit, a mid-cell setup transition, or a malformed bit. The block reports one event per clock. It also tracks carrier, meaning the line is busy, and it flags the end of each packet. When the line stays quiet while high, it flags a jam.

The event output is a stream with no back-pressure. A line that is being sampled cannot be stalled, so a nonzero event code is valid for exactly one cycle and the consumer must take it in that cycle. Carrier, end-of-packet, jam and the sample counter are plain status pins. A collision-report enable decides whether malformed bits appear as collision events or are dropped silently. The first bit of each packet is the start bit, and it is marked so that downstream logic can discard it.

Top module: `phase_line_decoder`

## Requirements
- R1: A synchronous reset clears the event code to none (0), carrier, start, end-of-packet and jam to 0, and the sample counter to 0. A reset during a packet also drops carrier.
- R2: The sample counter reloads to 1 on every accepted data transition. Otherwise it adds 1 per sample and saturates at 15.
- R3: While carrier is low, a rising transition raises carrier and emits event one (3) with the start flag set. A falling transition while carrier is low causes no event and leaves carrier low.
- R4: While carrier is high, a transition 6 to 10 samples after the last data transition is a data bit. A rising transition emits one (3) and a falling transition emits zero (2). The event appears two clocks after the sample that carries the change.
- R5: A transition 2 to 5 samples after the last data transition is a setup transition. It emits no event and does not reload the counter.
- R6: A transition exactly one sample after any previous transition is a too-many-transitions collision (event 1). It does not reload the counter.
- R7: A transition 11 or 12 samples after the last data transition is a too-few-transitions collision (event 1), and it reloads the counter.
- R8: If 12 samples pass after the last data transition with no transition and the line is low, end-of-packet pulses for one cycle and carrier drops.
- R9: If the same timeout happens with the line high, jam pulses for one cycle instead, carrier drops, and a collision event is emitted. End-of-packet and jam never pulse together.
- R10: When the collision-report enable is low, every collision is reported as event none. Data decoding, carrier, end-of-packet and jam behave as when the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, eight per nominal bit cell |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Raw phase-encoded line sample |
| coll_report_en_i | input | 1 | Enables collision events |
| evt_o | output | 2 | Event: 0 none, 1 collision, 2 zero, 3 one |
| start_o | output | 1 | Marks the event that is the packet's start bit |
| carrier_o | output | 1 | Line is carrying a packet |
| eop_o | output | 1 | One-cycle end-of-packet pulse (line low) |
| jam_o | output | 1 | One-cycle jam pulse (line high at timeout) |
| cnt_o | output | 4 | Samples since the last data transition |

## Verification
Packets are sent at the shortest (6), nominal (8) and longest (10) cell lengths. The bit patterns mix long runs and alternations, so many cells need a setup transition and the bench can confirm that setup transitions add no events. Each malformed pattern targets one class and no other: a one-sample glitch for too-many, a late edge at 11 samples for too-few, and a high line held past the timeout for jam. The glitch pattern is repeated with the report enable low, which shows that suppression changes only the event code. Idle behaviour is checked with a counter that saturates, a falling edge after a jam, and a reset issued mid-packet.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_COLL = 2'd1,
    EV_ZERO = 2'd2,
    EV_ONE  = 2'd3
  } pd_evt_e;

  // One sampled view of the line: current level and change against the previous sample.
  typedef struct packed {
    logic toggle;
    logic rise;
    logic level;
  } pd_smp_t;

endpackage

// File: rtl/pd_sampler.sv
module pd_sampler
  import pd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    line_i,
  output pd_smp_t smp_o
);

  logic cur_q;
  logic old_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= 1'b0;
      old_q <= 1'b0;
    end else begin
      cur_q <= line_i;
      old_q <= cur_q;
    end
  end

  always_comb begin
    smp_o.level  = cur_q;
    smp_o.toggle = cur_q ^ old_q;
    smp_o.rise   = cur_q & ~old_q;
  end

endmodule

// File: rtl/pd_counter.sv
module pd_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] ONE_V = W'(1);
  localparam logic [W-1:0] TOP_V = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= ONE_V;
    end else if (cnt_q != TOP_V) begin
      cnt_q <= cnt_q + ONE_V;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pd_classifier.sv
module pd_classifier
  import pd_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int GAP_W     = 2,
  parameter int MANY_GAP  = 1,
  parameter int SETUP_MIN = 2,
  parameter int DATA_MIN  = 6,
  parameter int DATA_MAX  = 10,
  parameter int FEW_MAX   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  pd_smp_t          smp_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             coll_en_i,
  output logic             restart_o,
  output logic [1:0]       evt_o,
  output logic             start_o,
  output logic             carrier_o,
  output logic             eop_o,
  output logic             jam_o
);

  localparam logic [GAP_W-1:0] L_MANY      = GAP_W'(MANY_GAP);
  localparam logic [CNT_W-1:0] L_SETUP_MIN = CNT_W'(SETUP_MIN);
  localparam logic [CNT_W-1:0] L_DATA_MIN  = CNT_W'(DATA_MIN);
  localparam logic [CNT_W-1:0] L_DATA_MAX  = CNT_W'(DATA_MAX);
  localparam logic [CNT_W-1:0] L_FEW_MAX   = CNT_W'(FEW_MAX);

  pd_evt_e evt_q, evt_d;
  logic    carrier_q, carrier_d;
  logic    start_q, start_d;
  logic    eop_q, eop_d;
  logic    jam_q, jam_d;
  logic    coll;

  always_comb begin
    restart_o = 1'b0;
    carrier_d = carrier_q;
    evt_d     = EV_NONE;
    start_d   = 1'b0;
    eop_d     = 1'b0;
    jam_d     = 1'b0;
    coll      = 1'b0;
    if (!carrier_q) begin
      // Idle: only a rising edge can open a packet (start bit is a one).
      if (smp_i.toggle && smp_i.rise) begin
        restart_o = 1'b1;
        carrier_d = 1'b1;
        evt_d     = EV_ONE;
        start_d   = 1'b1;
      end
    end else if (smp_i.toggle) begin
      if (gap_i <= L_MANY) begin
        coll = 1'b1;
      end else if (cnt_i >= L_SETUP_MIN && cnt_i < L_DATA_MIN) begin
        // mid-cell setup transition: nothing to report
        coll = 1'b0;
      end else if (cnt_i >= L_DATA_MIN && cnt_i <= L_DATA_MAX) begin
        restart_o = 1'b1;
        evt_d     = smp_i.rise ? EV_ONE : EV_ZERO;
      end else if (cnt_i > L_DATA_MAX && cnt_i <= L_FEW_MAX) begin
        restart_o = 1'b1;
        coll      = 1'b1;
      end else begin
        coll = 1'b1;
      end
    end else if (cnt_i >= L_FEW_MAX) begin
      carrier_d = 1'b0;
      if (smp_i.level) begin
        jam_d = 1'b1;
        coll  = 1'b1;
      end else begin
        eop_d = 1'b1;
      end
    end
    if (coll && coll_en_i) begin
      evt_d = EV_COLL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q     <= EV_NONE;
      carrier_q <= 1'b0;
      start_q   <= 1'b0;
      eop_q     <= 1'b0;
      jam_q     <= 1'b0;
    end else begin
      evt_q     <= evt_d;
      carrier_q <= carrier_d;
      start_q   <= start_d;
      eop_q     <= eop_d;
      jam_q     <= jam_d;
    end
  end

  assign evt_o     = evt_q;
  assign carrier_o = carrier_q;
  assign start_o   = start_q;
  assign eop_o     = eop_q;
  assign jam_o     = jam_q;

endmodule

// File: rtl/phase_line_decoder.sv
module phase_line_decoder
  import pd_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SETUP_MIN = 2,
  parameter int DATA_MIN  = 6,
  parameter int DATA_MAX  = 10,
  parameter int FEW_MAX   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  input  logic             coll_report_en_i,
  output logic [1:0]       evt_o,
  output logic             start_o,
  output logic             carrier_o,
  output logic             eop_o,
  output logic             jam_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int MANY_GAP = 1;
  localparam int GAP_W    = $clog2(MANY_GAP + 3);

  pd_smp_t          smp;
  logic             restart;
  logic [GAP_W-1:0] gap;

  pd_sampler u_smp (
    .clk    (clk),
    .rst    (rst),
    .line_i (line_i),
    .smp_o  (smp)
  );

  // samples since the last accepted data transition
  pd_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .cnt_o     (cnt_o)
  );

  // samples since any transition, for the too-many check
  pd_counter #(.W(GAP_W)) u_gap (
    .clk       (clk),
    .rst       (rst),
    .restart_i (smp.toggle),
    .cnt_o     (gap)
  );

  pd_classifier #(
    .CNT_W     (CNT_W),
    .GAP_W     (GAP_W),
    .MANY_GAP  (MANY_GAP),
    .SETUP_MIN (SETUP_MIN),
    .DATA_MIN  (DATA_MIN),
    .DATA_MAX  (DATA_MAX),
    .FEW_MAX   (FEW_MAX)
  ) u_cls (
    .clk       (clk),
    .rst       (rst),
    .smp_i     (smp),
    .cnt_i     (cnt_o),
    .gap_i     (gap),
    .coll_en_i (coll_report_en_i),
    .restart_o (restart),
    .evt_o     (evt_o),
    .start_o   (start_o),
    .carrier_o (carrier_o),
    .eop_o     (eop_o),
    .jam_o     (jam_o)
  );

endmodule

// File: rtl/phase_line_decoder_chk.sv
module phase_line_decoder_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             coll_report_en_i,
  input logic [1:0]       evt_o,
  input logic             start_o,
  input logic             carrier_o,
  input logic             eop_o,
  input logic             jam_o,
  input logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] TOP_V = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  AST_DATA_RELOADS_CNT: assert property (@(posedge clk) disable iff (rst)
    (evt_o == 2'd2 || evt_o == 2'd3) |-> cnt_o == ONE_V); // R2

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt_o == TOP_V |=> (cnt_o == TOP_V || cnt_o == ONE_V)); // R2

  AST_START_IS_ONE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (evt_o == 2'd3 && !$past(carrier_o))); // R3

  AST_DATA_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (rst)
    (evt_o == 2'd2 || evt_o == 2'd3) |-> carrier_o); // R4

  AST_END_DROPS_CARRIER: assert property (@(posedge clk) disable iff (rst)
    (eop_o || jam_o) |-> (!carrier_o && $past(carrier_o))); // R8

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(eop_o && jam_o)); // R9

  AST_JAM_REPORTS: assert property (@(posedge clk) disable iff (rst)
    (jam_o && $past(coll_report_en_i)) |-> evt_o == 2'd1); // R9

  AST_COLL_GATED: assert property (@(posedge clk) disable iff (rst)
    evt_o == 2'd1 |-> $past(coll_report_en_i)); // R10

endmodule

bind phase_line_decoder phase_line_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .coll_report_en_i (coll_report_en_i),
  .evt_o            (evt_o),
  .start_o          (start_o),
  .carrier_o        (carrier_o),
  .eop_o            (eop_o),
  .jam_o            (jam_o),
  .cnt_o            (cnt_o)
);

// File: tb/tb_phase_line_decoder.sv
module tb_phase_line_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line = 1'b0;
  logic       coll_en = 1'b1;
  logic [1:0] evt;
  logic       start_s, carrier, eop, jam;
  logic [3:0] cnt;

  int checks = 0;
  int failures = 0;

  logic [15:0] got;
  int got_n, n_start, n_coll, n_eop, n_jam;
  logic lvl;

  always #5 clk = ~clk;

  phase_line_decoder dut (
    .clk              (clk),
    .rst              (rst),
    .line_i           (line),
    .coll_report_en_i (coll_en),
    .evt_o            (evt),
    .start_o          (start_s),
    .carrier_o        (carrier),
    .eop_o            (eop),
    .jam_o            (jam),
    .cnt_o            (cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    got = '0; got_n = 0; n_start = 0; n_coll = 0; n_eop = 0; n_jam = 0;
  endtask

  task automatic observe();
    if (evt == 2'd3 || evt == 2'd2) begin
      if (start_s) n_start++;
      else begin got = {got[14:0], evt[0]}; got_n++; end
    end
    if (evt == 2'd1) n_coll++;
    if (eop) n_eop++;
    if (jam) n_jam++;
  endtask

  task automatic drive_sample(input logic v);
    @(negedge clk);
    observe();
    line = v;
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) drive_sample(v);
  endtask

  task automatic send_start();
    drive_sample(1'b1);
    lvl = 1'b1;
  endtask

  task automatic send_bit(input logic b, input int len);
    if (lvl == b) begin
      hold(lvl, len / 2 - 1);
      hold(~b, len - len / 2);
    end else begin
      hold(lvl, len - 1);
    end
    drive_sample(b);
    lvl = b;
  endtask

  task automatic end_low(input int len);
    if (lvl) hold(1'b1, len / 2 - 1);
    hold(1'b0, 20);
    lvl = 1'b0;
  endtask

  task automatic test_reset();
    rst = 1'b1; line = 1'b0; lvl = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 evt after reset", evt, 0);
    chk("R1 carrier after reset", carrier, 0);
    chk("R1 cnt after reset", cnt, 0);
    chk("R1 eop/jam after reset", {eop, jam}, 0);
    rst = 1'b0;
    clear_log();
    send_start();
    hold(1'b1, 3);
    chk("R1 carrier up before mid-packet reset", carrier, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 carrier after mid-packet reset", carrier, 0);
    chk("R1 evt after mid-packet reset", evt, 0);
    line = 1'b0; lvl = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_packet(input logic [15:0] pat, input int len);
    clear_log();
    hold(1'b0, 16);
    send_start();
    for (int i = 15; i >= 0; i--) send_bit(pat[i], len);
    end_low(len);
    chk($sformatf("R4 bits len=%0d", len), got, pat);
    chk($sformatf("R5 event count len=%0d", len), got_n, 16);
    chk($sformatf("R3 start flag len=%0d", len), n_start, 1);
    chk($sformatf("R8 eop len=%0d", len), n_eop, 1);
    chk($sformatf("R8 carrier after len=%0d", len), carrier, 0);
    chk($sformatf("R6 no collision len=%0d", len), n_coll, 0);
  endtask

  task automatic test_counter();
    clear_log();
    hold(1'b0, 20);
    chk("R2 counter saturates at 15", cnt, 15);
    chk("R3 carrier low when idle", carrier, 0);
    send_start();
    hold(1'b1, 2);
    chk("R2 counter reload to 1", cnt, 1);
    chk("R3 carrier up on start", carrier, 1);
    hold(1'b1, 3);
    chk("R2 counter counts samples", cnt, 4);
    hold(1'b1, 20);
    hold(1'b0, 20);
    lvl = 1'b0;
  endtask

  task automatic test_many(input logic en);
    coll_en = en;
    clear_log();
    hold(1'b0, 16);
    send_start();
    send_bit(1'b0, 8);
    drive_sample(1'b1);
    drive_sample(1'b0);
    hold(1'b0, 20);
    if (en) chk("R6 too-many collisions", n_coll, 2);
    else chk("R10 collisions suppressed", n_coll, 0);
    chk(en ? "R6 data bits" : "R10 data bits", got_n, 1);
    chk(en ? "R6 eop" : "R10 eop", n_eop, 1);
    chk(en ? "R6 carrier" : "R10 carrier", carrier, 0);
    coll_en = 1'b1;
  endtask

  task automatic test_few();
    clear_log();
    hold(1'b0, 16);
    send_start();
    hold(1'b1, 10);
    drive_sample(1'b0);
    lvl = 1'b0;
    hold(1'b0, 20);
    chk("R7 too-few collision", n_coll, 1);
    chk("R7 no data bit", got_n, 0);
    chk("R7 eop after", n_eop, 1);
  endtask

  task automatic test_jam();
    clear_log();
    hold(1'b0, 16);
    send_start();
    hold(1'b1, 20);
    chk("R9 jam pulse", n_jam, 1);
    chk("R9 no eop", n_eop, 0);
    chk("R9 collision on jam", n_coll, 1);
    chk("R9 carrier dropped", carrier, 0);
    clear_log();
    hold(1'b0, 20);
    lvl = 1'b0;
    chk("R3 idle falling edge no events", n_start + got_n + n_coll + n_eop + n_jam, 0);
    chk("R3 idle falling edge carrier", carrier, 0);
  endtask

  initial begin
    test_reset();
    test_packet(16'hA5C3, 8);
    test_packet(16'h0FF0, 6);
    test_packet(16'h3C96, 10);
    test_counter();
    test_many(1'b1);
    test_many(1'b0);
    test_few();
    test_jam();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

endmodule